// File: doc/BRIEF.md
# Receive delimiter and carrier detector

This block sits behind the symbol decoder of a 100 Mbps receive path. It reads one 5-bit code group each time a strobe is high. From that stream it produces four status outputs for a MAC: carrier sense, receive data valid, receive error and collision.

A frame opens when a J code group is followed directly by a K code group. The frame closes normally when a T code group is followed directly by an R code group. When idle arrives inside a frame with no T/R pair before it, the frame is cut short: receive error pulses for one cycle, and then everything drops. Code groups inside a frame that are not data are reported through receive error. Collision is a combinational AND of half-duplex mode, transmit enable and carrier. It is the only output that does not wait for a clock edge.

Top module: `rx_carrier_detect`

## Requirements
- R1: Code groups are read only in cycles where `sym_vld` is high. When a strobed J (11000) is followed by a strobed K (10001), `crs` is high in the cycle after the K strobe. Strobe-free cycles between J and K are allowed.
- R2: Inside a frame, a strobed T (01101) followed by a strobed R (00111) drops `crs`, `rx_dv` and `rx_er` in the cycle after the R strobe.
- R3: Inside a frame, a strobed IDLE (11111) that does not come after a T/R pair makes `rx_er` equal to the current `rx_dv` for one cycle, with `crs` still high. In the next cycle `crs`, `rx_dv` and `rx_er` are all low, whatever the inputs are. A strobe that falls in that clearing cycle is discarded.
- R4: `rx_dv` rises in the cycle after the first strobed code group that follows J/K and is neither T nor IDLE. It then stays high until carrier drops, and it falls together with carrier.
- R5: In a frame, `rx_er` is high for the cycle after a strobed code group that is not one of the 16 data groups and is not T or IDLE. The same applies to a T that is not followed by R, in which case the group after the T is flagged. The data groups are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101. A strobe carrying a data group clears `rx_er`. `rx_er` holds its value while no strobe arrives.
- R6: `rx_er` is never high while `rx_dv` is low. This includes an IDLE that arrives straight after J/K.
- R7: A J followed by any strobed group other than K or J returns the block to the search state without raising carrier. A repeated J keeps the search waiting for K.
- R8: `col` equals `half_dup AND tx_en AND crs` without delay. `col` is low whenever `half_dup` is low.
- R9: Cycles with `sym_vld` low leave `crs`, `rx_dv` and `rx_er` unchanged. The only exception is the clearing cycle of R3.
- R10: While `rst` is high, and in the cycle after it is released, `crs`, `rx_dv` and `rx_er` are low. The block searches for J/K again after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_vld | input | 1 | Code-group strobe |
| sym | input | 5 | Decoded 5-bit code group |
| tx_en | input | 1 | Local transmitter active |
| half_dup | input | 1 | High selects half-duplex operation |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| col | output | 1 | Collision indication |

## Verification
The bench goes after these cases:
- IDLE straight after J/K. A design that gates the error wrongly flags `rx_er` with no valid data.
- IDLE in the middle of a frame. A design that skips the error pulse, or drops carrier at once, fails R3.
- A lone T followed by data. A design that treats T alone as the end of a frame loses the frame.
- A J followed by a non-K group. A design that remembers J too long opens false frames.
- Gaps in the strobe inside each pattern. A design that advances on every clock, rather than on each strobe, shows it here.
- Collision with every combination of duplex and transmit enable. A registered `col` appears one cycle late.

// File: rtl/cgdet_pkg.sv
package cgdet_pkg;
  localparam int CG_W     = 5;
  localparam int N_DATA   = 16;

  typedef logic [CG_W-1:0] cg_t;

  localparam cg_t CG_J    = 5'b11000;
  localparam cg_t CG_K    = 5'b10001;
  localparam cg_t CG_T    = 5'b01101;
  localparam cg_t CG_R    = 5'b00111;
  localparam cg_t CG_IDLE = 5'b11111;

  typedef enum logic [2:0] {
    ST_SEARCH,
    ST_SAW_J,
    ST_FRAME,
    ST_SAW_T,
    ST_ABORT
  } det_st_e;

  typedef struct packed {
    logic is_data;
    logic is_j;
    logic is_k;
    logic is_t;
    logic is_r;
    logic is_idle;
  } cg_cls_t;

  // 4B5B data code group for nibble value nib
  function automatic cg_t data_code(input int unsigned nib);
    cg_t c;
    case (nib)
      0:  c = 5'b11110;  1:  c = 5'b01001;
      2:  c = 5'b10100;  3:  c = 5'b10101;
      4:  c = 5'b01010;  5:  c = 5'b01011;
      6:  c = 5'b01110;  7:  c = 5'b01111;
      8:  c = 5'b10010;  9:  c = 5'b10011;
      10: c = 5'b10110;  11: c = 5'b10111;
      12: c = 5'b11010;  13: c = 5'b11011;
      14: c = 5'b11100;  default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/cgdet_classify.sv
module cgdet_classify
  import cgdet_pkg::*;
#(
  parameter int NDATA = N_DATA
) (
  input  cg_t     sym,
  output cg_cls_t cls
);
  logic [NDATA-1:0] hit;

  for (genvar i = 0; i < NDATA; i++) begin : g_data
    assign hit[i] = (sym == data_code(i));
  end

  always_comb begin
    cls.is_data = |hit;
    cls.is_j    = (sym == CG_J);
    cls.is_k    = (sym == CG_K);
    cls.is_t    = (sym == CG_T);
    cls.is_r    = (sym == CG_R);
    cls.is_idle = (sym == CG_IDLE);
  end
endmodule

// File: rtl/cgdet_frame_fsm.sv
module cgdet_frame_fsm
  import cgdet_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sym_vld,
  input  cg_cls_t cls,
  output logic    crs,
  output logic    rx_dv,
  output logic    rx_er
);
  det_st_e st_q;
  logic    crs_q, dv_q, er_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_SEARCH;
      crs_q <= 1'b0;
      dv_q  <= 1'b0;
      er_q  <= 1'b0;
    end else if (st_q == ST_ABORT) begin
      st_q  <= ST_SEARCH;
      crs_q <= 1'b0;
      dv_q  <= 1'b0;
      er_q  <= 1'b0;
    end else if (sym_vld) begin
      er_q <= 1'b0;
      unique case (st_q)
        ST_SEARCH: begin
          if (cls.is_j) st_q <= ST_SAW_J;
        end
        ST_SAW_J: begin
          if (cls.is_k) begin
            st_q  <= ST_FRAME;
            crs_q <= 1'b1;
          end else if (!cls.is_j) begin
            st_q <= ST_SEARCH;
          end
        end
        ST_FRAME: begin
          if (cls.is_t) begin
            st_q <= ST_SAW_T;
          end else if (cls.is_idle) begin
            er_q <= dv_q;
            st_q <= ST_ABORT;
          end else begin
            dv_q <= 1'b1;
            er_q <= !cls.is_data;
          end
        end
        ST_SAW_T: begin
          if (cls.is_r) begin
            st_q  <= ST_SEARCH;
            crs_q <= 1'b0;
            dv_q  <= 1'b0;
          end else if (cls.is_idle) begin
            er_q <= dv_q;
            st_q <= ST_ABORT;
          end else begin
            dv_q <= 1'b1;
            er_q <= 1'b1;
            st_q <= ST_FRAME;
          end
        end
        default: st_q <= ST_SEARCH;
      endcase
    end
  end

  assign crs   = crs_q;
  assign rx_dv = dv_q;
  assign rx_er = er_q;
endmodule

// File: rtl/cgdet_col.sv
module cgdet_col (
  input  logic half_dup,
  input  logic tx_en,
  input  logic crs,
  output logic col
);
  assign col = half_dup & tx_en & crs;
endmodule

// File: rtl/rx_carrier_detect.sv
module rx_carrier_detect
  import cgdet_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            sym_vld,
  input  logic [CG_W-1:0] sym,
  input  logic            tx_en,
  input  logic            half_dup,
  output logic            crs,
  output logic            rx_dv,
  output logic            rx_er,
  output logic            col
);
  cg_cls_t cls;

  cgdet_classify u_cls (
    .sym (sym),
    .cls (cls)
  );

  cgdet_frame_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .sym_vld (sym_vld),
    .cls     (cls),
    .crs     (crs),
    .rx_dv   (rx_dv),
    .rx_er   (rx_er)
  );

  cgdet_col u_col (
    .half_dup (half_dup),
    .tx_en    (tx_en),
    .crs      (crs),
    .col      (col)
  );
endmodule

// File: rtl/rx_carrier_detect_chk.sv
module rx_carrier_detect_chk (
  input logic       clk,
  input logic       rst,
  input logic       sym_vld,
  input logic [4:0] sym,
  input logic       tx_en,
  input logic       half_dup,
  input logic       crs,
  input logic       rx_dv,
  input logic       rx_er,
  input logic       col
);
  AST_ER_ONLY_WITH_DV: assert property (@(posedge clk) disable iff (rst)
    rx_er |-> rx_dv); // R6

  AST_DV_INSIDE_CRS: assert property (@(posedge clk) disable iff (rst)
    rx_dv |-> crs); // R4

  AST_DV_FALLS_WITH_CRS: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_dv) |-> !crs); // R4

  AST_CRS_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(crs) |-> $past(sym_vld)); // R9

  AST_COL_FULL_DUPLEX_QUIET: assert property (@(posedge clk) disable iff (rst)
    !half_dup |-> !col); // R8

  AST_COL_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    col |-> (tx_en && crs)); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!crs && !rx_dv && !rx_er)); // R10
endmodule

bind rx_carrier_detect rx_carrier_detect_chk u_chk (.*);

// File: tb/rx_carrier_detect_bench.sv
module rx_carrier_detect_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_vld = 1'b0;
  logic [4:0] sym = 5'b0;
  logic       tx_en = 1'b0;
  logic       half_dup = 1'b0;
  logic       crs, rx_dv, rx_er, col;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                         R = 5'b00111, I = 5'b11111;

  // model state: 0 search, 1 saw J, 2 frame, 3 saw T, 4 clearing
  int   m_st = 0;
  logic m_crs = 1'b0, m_dv = 1'b0, m_er = 1'b0;

  always #5 clk = ~clk;

  rx_carrier_detect u_rx_carrier_detect (
    .clk(clk), .rst(rst), .sym_vld(sym_vld), .sym(sym), .tx_en(tx_en),
    .half_dup(half_dup), .crs(crs), .rx_dv(rx_dv), .rx_er(rx_er), .col(col)
  );

  function automatic logic [4:0] dcode(input int n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n % 16];
  endfunction

  function automatic logic [4:0] badcode(input int n);
    logic [4:0] t [11] = '{5'b00000, 5'b00001, 5'b00010, 5'b00011,
                           5'b00100, 5'b00101, 5'b00110, 5'b01000,
                           5'b01100, 5'b10000, 5'b11001};
    return t[n % 11];
  endfunction

  function automatic bit is_data(input logic [4:0] s);
    for (int i = 0; i < 16; i++) if (dcode(i) == s) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_step(input logic v, input logic [4:0] s);
    if (m_st == 4) begin
      m_st = 0; m_crs = 0; m_dv = 0; m_er = 0;
      return;
    end
    if (!v) return;
    m_er = 0;
    case (m_st)
      0: if (s == J) m_st = 1;
      1: if (s == K) begin m_st = 2; m_crs = 1; end
         else if (s != J) m_st = 0;
      2: if (s == T) m_st = 3;
         else if (s == I) begin m_er = m_dv; m_st = 4; end
         else begin m_dv = 1; m_er = !is_data(s); end
      default: if (s == R) begin m_st = 0; m_crs = 0; m_dv = 0; end
         else if (s == I) begin m_er = m_dv; m_st = 4; end
         else begin m_dv = 1; m_er = 1; m_st = 2; end
    endcase
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 crs", crs, m_crs);
    chk("R4 rx_dv", rx_dv, m_dv);
    chk("R5 rx_er", rx_er, m_er);
    chk("R8 col", col, half_dup & tx_en & m_crs);
  endtask

  // drive at negedge, check at next negedge
  task automatic cyc(input logic v, input logic [4:0] s);
    sym_vld = v; sym = s;
    model_step(v, s);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1; sym_vld = 1'b0;
    @(negedge clk); @(negedge clk);
    m_st = 0; m_crs = 0; m_dv = 0; m_er = 0;
    chk("R10 crs", crs, 1'b0);
    chk("R10 rx_dv", rx_dv, 1'b0);
    chk("R10 rx_er", rx_er, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    compare_all();
  endtask

  task automatic rnd_frame();
    int n;
    cyc(1, J); cyc(1, K);
    n = int'($urandom % 12) + 1;
    for (int i = 0; i < n; i++) begin
      if ($urandom % 5 == 0) cyc(0, 5'b0);
      if ($urandom % 8 == 0) cyc(1, badcode($urandom));
      else cyc(1, dcode($urandom));
    end
    case ($urandom % 3)
      0: begin cyc(1, T); cyc(1, R); end
      1: cyc(1, I);
      default: begin cyc(1, T); cyc(1, dcode($urandom)); cyc(1, T); cyc(1, R); end
    endcase
    cyc(1, I); cyc(1, I);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C5_0BEE));
    @(negedge clk);
    do_reset();

    // R1/R4/R2: clean frame with a strobe gap between J and K
    cyc(1, I); cyc(1, J); cyc(0, 5'b0);
    cyc(1, K); chk("R1 crs after J/K", crs, 1'b1); chk("R4 no dv yet", rx_dv, 1'b0);
    cyc(1, dcode(5)); chk("R4 dv first data", rx_dv, 1'b1);
    cyc(1, dcode(9));
    cyc(0, 5'b0); chk("R9 hold dv", rx_dv, 1'b1);
    cyc(1, T); chk("R2 crs held at T", crs, 1'b1);
    cyc(1, R); chk("R2 crs drop", crs, 1'b0); chk("R2 dv drop", rx_dv, 1'b0);

    // R5: coding error mid frame, error holds across a gap, cleared by data
    cyc(1, J); cyc(1, K); cyc(1, dcode(1));
    cyc(1, badcode(3)); chk("R5 er on bad", rx_er, 1'b1);
    cyc(0, 5'b0); chk("R9 er held", rx_er, 1'b1);
    cyc(1, dcode(2)); chk("R5 er cleared", rx_er, 1'b0);
    // R5: T not followed by R
    cyc(1, T); cyc(1, dcode(4)); chk("R5 lone T", rx_er, 1'b1);
    chk("R5 crs kept", crs, 1'b1);
    // R3: premature idle
    cyc(1, I); chk("R3 er pulse", rx_er, 1'b1); chk("R3 crs still", crs, 1'b1);
    cyc(1, J); chk("R3 cleared", crs, 1'b0); chk("R3 er low", rx_er, 1'b0);
    cyc(1, K); chk("R3 J discarded", crs, 1'b0);

    // R6: idle right after J/K
    cyc(1, J); cyc(1, K); cyc(1, I);
    chk("R6 no er without dv", rx_er, 1'b0);
    cyc(0, 5'b0); chk("R6 cleared", crs, 1'b0);

    // R7: J then non-K, and repeated J
    cyc(1, J); cyc(1, dcode(0)); cyc(1, K); chk("R7 no crs", crs, 1'b0);
    cyc(1, J); cyc(1, J); cyc(1, K); chk("R7 J J K", crs, 1'b1);

    // R8: collision across duplex and tx_en
    for (int m = 0; m < 4; m++) begin
      half_dup = m[0]; tx_en = m[1];
      cyc(1, dcode(m));
      chk("R8 col", col, m[0] & m[1]);
    end
    cyc(1, T); cyc(1, R);
    chk("R8 col after end", col, 1'b0);

    // R10: reset mid frame
    cyc(1, J); cyc(1, K); cyc(1, dcode(3));
    do_reset();

    // random frames and random symbol soup
    for (int f = 0; f < 150; f++) begin
      half_dup = $urandom % 2; tx_en = $urandom % 2;
      rnd_frame();
    end
    for (int c = 0; c < 4000; c++) begin
      int p;
      logic [4:0] s;
      p = int'($urandom % 100);
      if (p < 15) s = J; else if (p < 30) s = K;
      else if (p < 65) s = dcode($urandom);
      else if (p < 73) s = T; else if (p < 81) s = R;
      else if (p < 89) s = I; else s = badcode($urandom);
      if ($urandom % 16 == 0) begin half_dup = $urandom % 2; tx_en = $urandom % 2; end
      cyc(($urandom % 8) != 0, s);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule